// File: doc/BRIEF.md
# SPI Configuration Register Bank with Readback

This block receives 32-bit configuration words for a frequency-synthesizer control core over a three-wire serial link: a serial clock, a data line and a latch strobe. Bits arrive most significant first and gather in a shift register. The latch strobe moves the gathered word into one of fourteen registers. The low four bits of the word pick that register. All serial pins and the reference clock are sampled by the system clock through synchronizer chains, so the whole block runs in one clock domain.

Register 12 is the control register. It sets the source of a multiplexed status pin, the readback field and the logic-level flag. It also sets whether a latch strobe is applied at once or held until the next falling edge of a reference clock. A master-reset bit in the same register clears the entire bank. The status pin can show fixed levels, the divider and lock-detect inputs, or half-rate copies of the divider inputs. It can also shift out, during the next serial access, either the word just written or a selected field.

Top module: `cfg_spi_bank`

## Requirements
- R1: A latched word whose bits [3:0] hold a value from 0 to 13 is stored whole in that register. Values 14 and 15 leave every register unchanged.
- R2: Data is taken on each rising serial-clock edge, most significant bit first. Clocking bits without a latch strobe leaves every register unchanged.
- R3: When a word with bit 22 set is stored in register 12, every register, register 12 included, reads zero one cycle later. After that, writes behave normally again.
- R4: With register 12 bit 20 at 0, a rising latch strobe stores the word with no reference clock activity.
- R5: With register 12 bit 20 at 1, a rising strobe only makes the word pending. The word is stored at the next falling reference edge, and a rising reference edge does not store it. A second strobe while a word is pending replaces the pending word.
- R6: Register 12 bits [31:28] pick the status pin source. Code 0 and codes 10 to 15 give high impedance (enable low). 1 gives high, 2 gives low, 3 the reference-divider input, 4 the feedback-divider input and 5 lock detect. 8 and 9 give the reference-divider and feedback-divider inputs halved: the halved signal toggles on each rising input edge and starts at 0 after reset.
- R7: With code 6, the pin shows, during the next serial access, the previously latched word, most significant bit first. The pin advances one bit after each rising serial-clock edge.
- R8: With code 7, the pin shifts out a readback value in the same way. The value is chosen by register 12 bits [19:14]: 1 selects register 0 bits [19:4] and 2 selects register 1 bits [10:4], each right-justified and zero-padded to 32 bits. Every other code gives 32 zeros.
- R9: The level-select output follows register 12 bit 27.
- R10: After reset, all registers read zero, the status pin is disabled and the level-select output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock |
| spi_data | input | 1 | Serial data in |
| spi_le | input | 1 | Latch strobe |
| ref_clk | input | 1 | Reference clock for deferred latching |
| ref_div | input | 1 | Reference-divider output |
| fb_div | input | 1 | Feedback-divider output |
| lock_det | input | 1 | Lock-detect signal |
| mux_out | output | 1 | Status pin value |
| mux_oe | output | 1 | Status pin enable (0 = high impedance) |
| level_hi | output | 1 | Logic-level select flag |
| cfg_flat | output | NUM_REGS*W | All registers, register n at bits [n*W +: W] |

## Verification
The hardest state to reach is a pending deferred word that a second strobe replaces before any falling reference edge. The bench first sets the deferral bit through a direct write. It then sends two words to the same address with the reference clock held still. It raises the reference clock and shows that nothing has been stored yet. Only then does it lower the reference clock and expect the second word. The readback and echo paths are checked bit by bit during the access that follows each setup write, so the order in which the output shifter loads and shifts is observed directly.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int CTRL_ADDR  = 12;
  localparam int MR_POS     = 22;
  localparam int LESYNC_POS = 20;
  localparam int LEVEL_POS  = 27;
  localparam int MUX_POS    = 28;
  localparam int MUX_W      = 4;
  localparam int RB_POS     = 14;
  localparam int RB_W       = 6;
  localparam int INT_POS    = 4;
  localparam int INT_W      = 16;
  localparam int FRAC_POS   = 4;
  localparam int FRAC_W     = 7;

  localparam logic [MUX_W-1:0] MX_HIZ     = 4'd0;
  localparam logic [MUX_W-1:0] MX_HIGH    = 4'd1;
  localparam logic [MUX_W-1:0] MX_LOW     = 4'd2;
  localparam logic [MUX_W-1:0] MX_REFDIV  = 4'd3;
  localparam logic [MUX_W-1:0] MX_FBDIV   = 4'd4;
  localparam logic [MUX_W-1:0] MX_LOCK    = 4'd5;
  localparam logic [MUX_W-1:0] MX_ECHO    = 4'd6;
  localparam logic [MUX_W-1:0] MX_RDBK    = 4'd7;
  localparam logic [MUX_W-1:0] MX_REFHALF = 4'd8;
  localparam logic [MUX_W-1:0] MX_FBHALF  = 4'd9;

  localparam logic [RB_W-1:0] RB_INT  = 6'd1;
  localparam logic [RB_W-1:0] RB_FRAC = 6'd2;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_chan
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], async_in[g]};
    end
    assign sync_lvl[g] = chain[STAGES-1];
    assign rise[g]     = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g]     = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/cfg_latch_ctrl.sv
module cfg_latch_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_rise,
  input  logic         sdata_lvl,
  input  logic         le_rise,
  input  logic         ref_fall,
  input  logic         sync_mode,
  output logic         fire,
  output logic [W-1:0] fire_word,
  output logic         pending
);
  logic [W-1:0] shift_q;
  logic [W-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      pend_word <= '0;
      pending   <= 1'b0;
      fire      <= 1'b0;
      fire_word <= '0;
    end else begin
      fire <= 1'b0;
      if (sclk_rise) shift_q <= {shift_q[W-2:0], sdata_lvl};
      if (le_rise) begin
        if (sync_mode) begin
          pending   <= 1'b1;
          pend_word <= shift_q;
        end else begin
          fire      <= 1'b1;
          fire_word <= shift_q;
        end
      end else if (pending && ref_fall) begin
        fire      <= 1'b1;
        fire_word <= pend_word;
        pending   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_spi_pkg::*;
#(
  parameter int W        = 32,
  parameter int NUM_REGS = 14,
  parameter int AW       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [W-1:0]          wr_word,
  output logic [NUM_REGS*W-1:0] regs_flat
);
  localparam logic [AW:0] REG_LIMIT = (AW+1)'(NUM_REGS);

  logic [W-1:0]  bank [NUM_REGS];
  logic [AW-1:0] wr_addr;
  logic          addr_ok;
  logic          mr_hit;

  assign wr_addr = wr_word[AW-1:0];
  assign addr_ok = {1'b0, wr_addr} < REG_LIMIT;
  assign mr_hit  = bank[CTRL_ADDR][MR_POS];

  always_ff @(posedge clk) begin
    if (rst || mr_hit) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (wr_en && addr_ok) begin
      bank[wr_addr] <= wr_word;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*W +: W] = bank[g];
  end
endmodule

// File: rtl/cfg_mux_out.sv
module cfg_mux_out
  import cfg_spi_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MUX_W-1:0]  mux_sel,
  input  logic [RB_W-1:0]   rb_sel,
  input  logic              level_bit,
  input  logic [INT_W-1:0]  int_field,
  input  logic [FRAC_W-1:0] frac_field,
  input  logic              fire,
  input  logic [W-1:0]      fire_word,
  input  logic              sclk_rise,
  input  logic              ref_div,
  input  logic              fb_div,
  input  logic              lock_det,
  output logic              mux_out,
  output logic              mux_oe,
  output logic              level_hi
);
  logic         reload_q;
  logic [W-1:0] out_sh;
  logic [W-1:0] rb_val;
  logic         ref_q, fb_q, ref_half, fb_half;
  logic         pin_val, pin_en;

  always_comb begin
    rb_val = '0;
    case (rb_sel)
      RB_INT:  rb_val[INT_W-1:0]  = int_field;
      RB_FRAC: rb_val[FRAC_W-1:0] = frac_field;
      default: rb_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= 1'b0;
      out_sh   <= '0;
    end else begin
      reload_q <= fire;
      if (reload_q) out_sh <= (mux_sel == MX_RDBK) ? rb_val : fire_word;
      else if (sclk_rise) out_sh <= {out_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0; fb_q <= 1'b0; ref_half <= 1'b0; fb_half <= 1'b0;
    end else begin
      ref_q <= ref_div;
      fb_q  <= fb_div;
      if (ref_div && !ref_q) ref_half <= ~ref_half;
      if (fb_div && !fb_q)   fb_half  <= ~fb_half;
    end
  end

  always_comb begin
    pin_en  = 1'b1;
    pin_val = 1'b0;
    case (mux_sel)
      MX_HIGH:    pin_val = 1'b1;
      MX_LOW:     pin_val = 1'b0;
      MX_REFDIV:  pin_val = ref_div;
      MX_FBDIV:   pin_val = fb_div;
      MX_LOCK:    pin_val = lock_det;
      MX_ECHO:    pin_val = out_sh[W-1];
      MX_RDBK:    pin_val = out_sh[W-1];
      MX_REFHALF: pin_val = ref_half;
      MX_FBHALF:  pin_val = fb_half;
      default:    pin_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_out  <= 1'b0;
      mux_oe   <= 1'b0;
      level_hi <= 1'b0;
    end else begin
      mux_out  <= pin_val;
      mux_oe   <= pin_en;
      level_hi <= level_bit;
    end
  end
endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
  import cfg_spi_pkg::*;
#(
  parameter int W           = 32,
  parameter int NUM_REGS    = 14,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_clk,
  input  logic                  spi_data,
  input  logic                  spi_le,
  input  logic                  ref_clk,
  input  logic                  ref_div,
  input  logic                  fb_div,
  input  logic                  lock_det,
  output logic                  mux_out,
  output logic                  mux_oe,
  output logic                  level_hi,
  output logic [NUM_REGS*W-1:0] cfg_flat
);
  localparam int CTRL_BASE = CTRL_ADDR * W;

  logic [3:0]   s_lvl, s_rise, s_fall;
  logic         sclk_rise, le_rise, ref_fall, sdata_lvl;
  logic         sync_mode;
  logic         fire, pending;
  logic [W-1:0] fire_word;
  logic         unused_edges;

  cfg_edge_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ref_clk, spi_le, spi_data, spi_clk}),
    .sync_lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign sclk_rise = s_rise[0];
  assign sdata_lvl = s_lvl[1];
  assign le_rise   = s_rise[2];
  assign ref_fall  = s_fall[3];
  assign unused_edges = ^{s_lvl[0], s_lvl[2], s_lvl[3], s_rise[1], s_rise[3],
                          s_fall[0], s_fall[1], s_fall[2]};

  assign sync_mode = cfg_flat[CTRL_BASE + LESYNC_POS];

  cfg_latch_ctrl #(.W(W)) u_latch (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sdata_lvl(sdata_lvl),
    .le_rise(le_rise), .ref_fall(ref_fall), .sync_mode(sync_mode),
    .fire(fire), .fire_word(fire_word), .pending(pending)
  );

  cfg_reg_file #(.W(W), .NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(fire), .wr_word(fire_word),
    .regs_flat(cfg_flat)
  );

  cfg_mux_out #(.W(W)) u_mux (
    .clk(clk), .rst(rst),
    .mux_sel(cfg_flat[CTRL_BASE + MUX_POS +: MUX_W]),
    .rb_sel(cfg_flat[CTRL_BASE + RB_POS +: RB_W]),
    .level_bit(cfg_flat[CTRL_BASE + LEVEL_POS]),
    .int_field(cfg_flat[INT_POS +: INT_W]),
    .frac_field(cfg_flat[W + FRAC_POS +: FRAC_W]),
    .fire(fire), .fire_word(fire_word), .sclk_rise(sclk_rise),
    .ref_div(ref_div), .fb_div(fb_div), .lock_det(lock_det),
    .mux_out(mux_out), .mux_oe(mux_oe), .level_hi(level_hi)
  );
endmodule

// File: rtl/cfg_spi_bank_chk.sv
module cfg_spi_bank_chk
  import cfg_spi_pkg::*;
#(
  parameter int W        = 32,
  parameter int NUM_REGS = 14
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_REGS*W-1:0] cfg_flat,
  input logic                  ref_div,
  input logic                  mux_out,
  input logic                  mux_oe,
  input logic                  fire,
  input logic [3:0]            fire_addr,
  input logic                  pending,
  input logic                  le_rise,
  input logic                  sync_mode
);
  localparam int CB = CTRL_ADDR * W;
  logic [MUX_W-1:0] sel;
  logic             mr;
  assign sel = cfg_flat[CB + MUX_POS +: MUX_W];
  assign mr  = cfg_flat[CB + MR_POS];

  AST_MR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mr |=> (cfg_flat == '0)); // R3
  AST_ADDR_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (fire && fire_addr >= 4'd14 && !mr) |=> $stable(cfg_flat)); // R1
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pending && !fire) |=> $stable(cfg_flat)); // R5
  AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (rst)
    (le_rise && sync_mode) |=> !fire); // R5
  AST_HIZ_CODES: assert property (@(posedge clk) disable iff (rst)
    (sel == MX_HIZ || sel >= 4'd10) |=> !mux_oe); // R6
  AST_REF_PASS: assert property (@(posedge clk) disable iff (rst)
    (sel == MX_REFDIV) |=> (mux_oe && mux_out == $past(ref_div))); // R6
endmodule

bind cfg_spi_bank cfg_spi_bank_chk #(.W(W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .cfg_flat(cfg_flat), .ref_div(ref_div),
  .mux_out(mux_out), .mux_oe(mux_oe), .fire(fire),
  .fire_addr(fire_word[3:0]), .pending(pending),
  .le_rise(le_rise), .sync_mode(sync_mode)
);

// File: tb/cfg_spi_bank_test.sv
`timescale 1ns/1ps
module cfg_spi_bank_test;
  localparam int W  = 32;
  localparam int NR = 14;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_clk = 1'b0, spi_data = 1'b0, spi_le = 1'b0, ref_clk = 1'b0;
  logic ref_div = 1'b0, fb_div = 1'b0, lock_det = 1'b0;
  logic mux_out, mux_oe, level_hi;
  logic [NR*W-1:0] cfg_flat;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_bank [NR];
  bit ref_par = 1'b0, fb_par = 1'b0;

  always #4 clk = ~clk;

  cfg_spi_bank uut (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_data(spi_data),
    .spi_le(spi_le), .ref_clk(ref_clk), .ref_div(ref_div), .fb_div(fb_div),
    .lock_det(lock_det), .mux_out(mux_out), .mux_oe(mux_oe),
    .level_hi(level_hi), .cfg_flat(cfg_flat)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++) chk(req, cfg_flat[i*W +: W], exp_bank[i]);
  endtask

  function automatic logic [31:0] ctrl(input logic [3:0] mx, input bit lvl,
                                       input bit sync, input logic [5:0] rb, input bit mr);
    logic [31:0] w = 32'h0;
    w[31:28] = mx; w[27] = lvl; w[22] = mr; w[20] = sync; w[19:14] = rb; w[3:0] = 4'd12;
    return w;
  endfunction

  task automatic apply(input logic [31:0] w);
    if (w[3:0] < 4'd14) exp_bank[w[3:0]] = w;
    if (w[3:0] == 4'd12 && w[22]) for (int i = 0; i < NR; i++) exp_bank[i] = '0;
  endtask

  task automatic spi_shift(input logic [31:0] w, input bit chk_en,
                           input logic [31:0] exp_out, input string req);
    for (int i = 31; i >= 0; i--) begin
      spi_data = w[i];
      tick(PH);
      if (chk_en) chk(req, {31'h0, mux_out}, {31'h0, exp_out[i]});
      spi_clk = 1'b1;
      tick(PH);
      spi_clk = 1'b0;
    end
  endtask

  task automatic le_pulse();
    tick(PH); spi_le = 1'b1; tick(PH); spi_le = 1'b0; tick(2*PH);
  endtask

  task automatic wr(input logic [31:0] w);
    spi_shift(w, 1'b0, 32'h0, "");
    le_pulse();
    apply(w);
  endtask

  task automatic ref_pulse();
    ref_clk = 1'b1; tick(PH); ref_clk = 1'b0; tick(2*PH);
  endtask

  task automatic drive_div(input bit r, input bit f, input bit l);
    if (r && !ref_div) ref_par = ~ref_par;
    if (f && !fb_div)  fb_par  = ~fb_par;
    ref_div = r; fb_div = f; lock_det = l;
    tick(3);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    bit eo, ev;
    for (int i = 0; i < NR; i++) exp_bank[i] = '0;
    tick(5); rst = 1'b0; tick(2);

    // R10 reset state
    check_bank("R10");
    chk("R10 oe", {31'h0, mux_oe}, 32'h0);
    chk("R10 level", {31'h0, level_hi}, 32'h0);

    // R2 shift without strobe, then strobe (MSB-first capture)
    w = 32'h8123_4565;
    spi_shift(w, 1'b0, 32'h0, "");
    tick(4*PH);
    check_bank("R2 no strobe");
    le_pulse(); apply(w);
    check_bank("R2 msb first");

    // R1 and R4: exhaustive address sweep, direct latching
    for (int a = 0; a < 16; a++) begin
      if (a == 12) w = ctrl(4'd2, 1'b0, 1'b0, 6'd0, 1'b0);
      else w = {(32'h5A3C_0000 ^ (32'(a) * 32'h0013_1711)) & 32'hFFFF_FFF0} | 32'(a);
      wr(w);
      check_bank("R1 R4 sweep");
    end
    chk("R6 low oe", {31'h0, mux_oe}, 32'h1);
    chk("R6 low val", {31'h0, mux_out}, 32'h0);

    // R6 source sweep
    for (int c = 0; c < 16; c++) begin
      if (c == 6 || c == 7) continue;
      wr(ctrl(4'(c), 1'b0, 1'b0, 6'd0, 1'b0));
      for (int p = 0; p < 8; p++) begin
        drive_div(p[0], p[1], p[2]);
        eo = 1'b1;
        case (c)
          1: ev = 1'b1;
          2: ev = 1'b0;
          3: ev = ref_div;
          4: ev = fb_div;
          5: ev = lock_det;
          8: ev = ref_par;
          9: ev = fb_par;
          default: begin eo = 1'b0; ev = 1'b0; end
        endcase
        chk($sformatf("R6 code %0d oe", c), {31'h0, mux_oe}, {31'h0, eo});
        if (eo) chk($sformatf("R6 code %0d val", c), {31'h0, mux_out}, {31'h0, ev});
      end
    end

    // R9 level flag
    wr(ctrl(4'd1, 1'b1, 1'b0, 6'd0, 1'b0));
    chk("R9 high", {31'h0, level_hi}, 32'h1);
    wr(ctrl(4'd1, 1'b0, 1'b0, 6'd0, 1'b0));
    chk("R9 low", {31'h0, level_hi}, 32'h0);

    // R7 echo of previous word
    wr(ctrl(4'd6, 1'b0, 1'b0, 6'd0, 1'b0));
    wr(32'hC3A5_9E13);
    w = 32'h1F0E_D2B4;
    spi_shift(w, 1'b1, 32'hC3A5_9E13, "R7 echo");
    le_pulse(); apply(w);
    w = 32'h7777_000E;
    spi_shift(w, 1'b1, 32'h1F0E_D2B4, "R7 echo");
    le_pulse(); apply(w);
    check_bank("R7 bank");

    // R8 readback fields
    wr({12'h123, 16'hBEEF, 4'h0});
    wr({21'h0A5A5, 7'h5A, 4'h1});
    wr(ctrl(4'd7, 1'b0, 1'b0, 6'd1, 1'b0));
    spi_shift(32'h0000_000F, 1'b1, 32'h0000_BEEF, "R8 int");
    le_pulse();
    wr(ctrl(4'd7, 1'b0, 1'b0, 6'd2, 1'b0));
    spi_shift(32'h0000_000F, 1'b1, 32'h0000_005A, "R8 frac");
    le_pulse();
    wr(ctrl(4'd7, 1'b0, 1'b0, 6'd0, 1'b0));
    spi_shift(32'hFFFF_FFFF, 1'b1, 32'h0, "R8 zero");
    le_pulse();
    wr(ctrl(4'd7, 1'b0, 1'b0, 6'h2A, 1'b0));
    spi_shift(32'hFFFF_FFFF, 1'b1, 32'h0, "R8 other");
    le_pulse();

    // R5 deferred latch with replacement
    wr(ctrl(4'd1, 1'b0, 1'b1, 6'd0, 1'b0));
    spi_shift(32'hAAAA_5552, 1'b0, 32'h0, ""); le_pulse();
    tick(20);
    check_bank("R5 pending");
    w = 32'h1234_ABC2;
    spi_shift(w, 1'b0, 32'h0, ""); le_pulse();
    ref_clk = 1'b1; tick(2*PH);
    check_bank("R5 rising ref");
    ref_clk = 1'b0; tick(2*PH);
    apply(w);
    check_bank("R5 replaced");
    w = ctrl(4'd1, 1'b0, 1'b0, 6'd0, 1'b0);
    spi_shift(w, 1'b0, 32'h0, ""); le_pulse(); ref_pulse(); apply(w);
    check_bank("R5 exit");
    wr(32'h0BAD_F006);
    check_bank("R4 direct");

    // R3 master reset
    wr(ctrl(4'd1, 1'b1, 1'b1, 6'd1, 1'b1));
    check_bank("R3 cleared");
    chk("R3 oe", {31'h0, mux_oe}, 32'h0);
    chk("R3 level", {31'h0, level_hi}, 32'h0);
    wr(32'h6543_2107);
    check_bank("R3 resume");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule